// File: doc/BRIEF.md
# Exception and Interrupt Dispatch Unit

This unit sits beside the fetch stage of a processor core and decides, once per cycle, whether control must move to a privileged handler. There are two kinds of cause. The first is a synchronous exception request, which carries a kind code and, for a call into privileged code, an 8-bit function code. The second is a set of four interrupt lines, each filtered by the current 3-bit interrupt priority level.

When a cause is accepted, the unit does three things on the same clock edge. It computes the handler address as the privileged-code base plus an offset that depends on the cause. It saves the interrupted PC with the current privileged-mode flag folded into bit 0. It asks the core to enter privileged mode. A memory-fault exception also captures three trap arguments: the faulting address, the fault code and the access type.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, every output is zero: redirect_valid, priv_set, kind_err, new_pc, exc_addr, err_code and the three trap arguments.
- R2: While priv_mode is 1, no interrupt is accepted, whatever the lines and level are.
- R3: An interrupt line is eligible only when ipl is at or below its ceiling. The lines are irq_lines[0] device (ceiling 3), [1] timer (ceiling 4), [2] inter-processor (ceiling 5) and [3] machine check (ceiling 6). No line is eligible at level 7.
- R4: Among the eligible lines, the highest bit index wins. The handler offsets are 0x080 for machine check, 0x100 for inter-processor, 0x180 for timer and 0x200 for device.
- R5: A synchronous request with kind k in 0..9 uses offset k*0x80. The kinds are 0 reset, 1 machine check, 2 inter-processor, 3 timer, 4 device, 5 memory fault, 6 unaligned, 7 illegal opcode, 8 arithmetic and 9 FP-disabled.
- R6: Kind 10 is a call into privileged code. If bit 7 of exc_code is set, the offset is 0x2000 + (exc_code-0x80)*64. Otherwise it is 0x1000 + exc_code*64.
- R7: On the edge that samples an accepted cause, the unit loads new_pc = pal_base + offset and exc_addr = pc_in | priv_mode. It also raises redirect_valid and priv_set, and both fall again on the next edge if no cause is present.
- R8: A valid synchronous request is taken in place of any interrupt that is pending in the same cycle.
- R9: A request with kind 11..15 pulses kind_err for one cycle. It causes no redirect and leaves new_pc, exc_addr and err_code unchanged.
- R10: A taken kind-5 request loads the trap arguments. trap_arg0 gets fault_addr and trap_arg1 gets the zero-extended fault_code. trap_arg2 gets 0 for fault_acc 0 (load), 1 for fault_acc 1 (store), and all ones for fault_acc 2 or 3 (fetch). Any other cause leaves the trap arguments unchanged.
- R11: A taken interrupt clears err_code to 0. A taken synchronous exception loads exc_code into err_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_kind | input | 4 | Exception kind code |
| exc_code | input | 8 | Function code for a privileged call |
| fault_addr | input | PC_W | Faulting address for a memory fault |
| fault_code | input | FC_W | Memory fault reason code |
| fault_acc | input | 2 | Access type: 0 load, 1 store, 2/3 fetch |
| irq_lines | input | 4 | Device, timer, inter-processor and machine-check requests |
| ipl | input | 3 | Current interrupt priority level |
| pc_in | input | PC_W | PC of the interrupted instruction |
| pal_base | input | PC_W | Privileged-code base address |
| priv_mode | input | 1 | Core is currently in privileged mode |
| redirect_valid | output | 1 | One-cycle pulse: new_pc is valid |
| new_pc | output | PC_W | Handler entry address |
| exc_addr | output | PC_W | Saved return address with mode in bit 0 |
| priv_set | output | 1 | Request to enter privileged mode |
| err_code | output | 8 | Error code register |
| kind_err | output | 1 | Undefined exception kind seen |
| trap_arg0 | output | PC_W | Faulting address |
| trap_arg1 | output | PC_W | Fault code |
| trap_arg2 | output | PC_W | Access type indicator |

## Verification
The interrupt path is swept over every combination of the four lines, the eight levels and both mode values. This separates the ceiling of each line from the winner chosen among several eligible lines, and it shows that privileged mode blocks everything. Every one of the 16 exception kinds is then sent with all interrupt lines asserted. That sweep separates the sequential offsets, the undefined-kind error path and the precedence of exceptions over interrupts. All 256 call codes exercise the boundary between the two banks at 0x7F and 0x80. The four access types confirm how the trap arguments are encoded, and the other kinds confirm that those arguments stay unchanged.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;

    localparam int OFF_W    = 16;
    localparam int CODE_W   = 8;
    localparam int KIND_W   = 4;
    localparam int IRQ_N    = 4;
    localparam int IRQ_BASE = 3;   // ceiling level of the lowest line

    typedef enum logic [KIND_W-1:0] {
        EK_RESET = 4'd0,
        EK_MCHK  = 4'd1,
        EK_IPI   = 4'd2,
        EK_CLK   = 4'd3,
        EK_DEV   = 4'd4,
        EK_MMF   = 4'd5,
        EK_UNAL  = 4'd6,
        EK_OPC   = 4'd7,
        EK_ARITH = 4'd8,
        EK_FPDIS = 4'd9,
        EK_CPRIV = 4'd10
    } ekind_t;

    typedef struct packed {
        logic              take;
        logic [KIND_W-1:0] kind;
    } irq_pick_t;

    typedef struct packed {
        logic              go;
        logic              bad;
        logic              is_irq;
        logic              mmf;
        logic [KIND_W-1:0] kind;
    } dispatch_t;

    function automatic logic kind_defined(input logic [KIND_W-1:0] k);
        return k <= KIND_W'(EK_CPRIV);
    endfunction

    function automatic logic [OFF_W-1:0] slot_offset(input logic [KIND_W-1:0] k,
                                                      input logic [CODE_W-1:0] code);
        logic [OFF_W-1:0] off;
        if (k == KIND_W'(EK_CPRIV)) begin
            if (code[CODE_W-1])
                off = 16'h2000 + {3'b0, code[CODE_W-2:0], 6'b0};
            else
                off = 16'h1000 + {2'b0, code, 6'b0};
        end else begin
            off = {5'b0, k, 7'b0};
        end
        return off;
    endfunction

endpackage

// File: rtl/exc_irq_arbiter.sv
module exc_irq_arbiter
    import exc_dispatch_pkg::*;
#(
    parameter int N    = IRQ_N,
    parameter int BASE = IRQ_BASE
) (
    input  logic [N-1:0] irq,
    input  logic [2:0]   ipl,
    input  logic         priv,
    output irq_pick_t    pick
);
    localparam int LVL_W = 4;

    logic [N-1:0] elig;

    for (genvar i = 0; i < N; i++) begin : g_elig
        localparam logic [LVL_W-1:0] CEIL = LVL_W'(BASE + i);
        assign elig[i] = irq[i] && !priv && ({1'b0, ipl} <= CEIL);
    end

    always_comb begin
        pick = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i]) begin
                pick.take = 1'b1;
                pick.kind = KIND_W'(EK_DEV) - KIND_W'(i);
            end
        end
    end
endmodule

// File: rtl/exc_cause_select.sv
module exc_cause_select
    import exc_dispatch_pkg::*;
(
    input  logic              exc_req,
    input  logic [KIND_W-1:0] exc_kind,
    input  irq_pick_t         pick,
    output dispatch_t         sel
);
    always_comb begin
        sel = '0;
        if (exc_req) begin
            if (kind_defined(exc_kind)) begin
                sel.go   = 1'b1;
                sel.kind = exc_kind;
                sel.mmf  = (exc_kind == KIND_W'(EK_MMF));
            end else begin
                sel.bad  = 1'b1;
            end
        end else if (pick.take) begin
            sel.go     = 1'b1;
            sel.is_irq = 1'b1;
            sel.kind   = pick.kind;
        end
    end
endmodule

// File: rtl/exc_trap_args.sv
module exc_trap_args #(
    parameter int PC_W = 64,
    parameter int FC_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [PC_W-1:0] addr,
    input  logic [FC_W-1:0] fcode,
    input  logic [1:0]      acc,
    output logic [PC_W-1:0] arg0,
    output logic [PC_W-1:0] arg1,
    output logic [PC_W-1:0] arg2
);
    always_ff @(posedge clk) begin
        if (rst) begin
            arg0 <= '0;
            arg1 <= '0;
            arg2 <= '0;
        end else if (load) begin
            arg0 <= addr;
            arg1 <= PC_W'(fcode);
            case (acc)
                2'd0:    arg2 <= '0;
                2'd1:    arg2 <= PC_W'(1);
                default: arg2 <= '1;
            endcase
        end
    end

    // R10: trap arguments only move on a memory-fault load
    p_trap_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(arg0) && $stable(arg1) && $stable(arg2)));
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
    import exc_dispatch_pkg::*;
#(
    parameter int PC_W = 64,
    parameter int FC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req,
    input  logic [3:0]        exc_kind,
    input  logic [7:0]        exc_code,
    input  logic [PC_W-1:0]   fault_addr,
    input  logic [FC_W-1:0]   fault_code,
    input  logic [1:0]        fault_acc,
    input  logic [3:0]        irq_lines,
    input  logic [2:0]        ipl,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PC_W-1:0]   pal_base,
    input  logic              priv_mode,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   new_pc,
    output logic [PC_W-1:0]   exc_addr,
    output logic              priv_set,
    output logic [7:0]        err_code,
    output logic              kind_err,
    output logic [PC_W-1:0]   trap_arg0,
    output logic [PC_W-1:0]   trap_arg1,
    output logic [PC_W-1:0]   trap_arg2
);
    irq_pick_t pick;
    dispatch_t sel;
    logic [OFF_W-1:0] off;

    exc_irq_arbiter #(.N(IRQ_N), .BASE(IRQ_BASE)) u_arb (
        .irq  (irq_lines),
        .ipl  (ipl),
        .priv (priv_mode),
        .pick (pick)
    );

    exc_cause_select u_sel (
        .exc_req  (exc_req),
        .exc_kind (exc_kind),
        .pick     (pick),
        .sel      (sel)
    );

    exc_trap_args #(.PC_W(PC_W), .FC_W(FC_W)) u_trap (
        .clk   (clk),
        .rst   (rst),
        .load  (sel.mmf),
        .addr  (fault_addr),
        .fcode (fault_code),
        .acc   (fault_acc),
        .arg0  (trap_arg0),
        .arg1  (trap_arg1),
        .arg2  (trap_arg2)
    );

    assign off = slot_offset(sel.kind, exc_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            priv_set       <= 1'b0;
            kind_err       <= 1'b0;
            new_pc         <= '0;
            exc_addr       <= '0;
            err_code       <= '0;
        end else begin
            redirect_valid <= sel.go;
            priv_set       <= sel.go;
            kind_err       <= sel.bad;
            if (sel.go) begin
                new_pc   <= pal_base + PC_W'(off);
                exc_addr <= pc_in | PC_W'(priv_mode);
                err_code <= sel.is_irq ? 8'h00 : exc_code;
            end
        end
    end

    // R2: privileged mode blocks interrupts
    p_no_irq_priv_r2: assert property (@(posedge clk) disable iff (rst)
        (priv_mode && !exc_req) |=> !redirect_valid);

    // R9: undefined kinds flag an error and never redirect
    p_bad_kind_r9: assert property (@(posedge clk) disable iff (rst)
        (exc_req && exc_kind > 4'd10) |=> (kind_err && !redirect_valid));

    // R8: a defined synchronous request is always taken
    p_exc_taken_r8: assert property (@(posedge clk) disable iff (rst)
        (exc_req && exc_kind <= 4'd10) |=> (redirect_valid && priv_set));

    // R7: saved address carries the mode flag in bit 0
    p_exc_addr_r7: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (exc_addr == ($past(pc_in) | PC_W'($past(priv_mode)))));

    // R11: an interrupt clears the error code
    p_irq_err_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && !$past(exc_req)) |-> (err_code == 8'h00));
endmodule

// File: tb/sim_exc_dispatch.sv
module sim_exc_dispatch;
    localparam int PERIOD = 10;
    localparam int PC_W = 64;
    localparam int FC_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic exc_req = 1'b0;
    logic [3:0] exc_kind = '0;
    logic [7:0] exc_code = '0;
    logic [PC_W-1:0] fault_addr = '0;
    logic [FC_W-1:0] fault_code = '0;
    logic [1:0] fault_acc = '0;
    logic [3:0] irq_lines = '0;
    logic [2:0] ipl = '0;
    logic [PC_W-1:0] pc_in = '0;
    logic [PC_W-1:0] pal_base = 64'h0000_0001_0000_0000;
    logic priv_mode = 1'b0;
    logic redirect_valid, priv_set, kind_err;
    logic [PC_W-1:0] new_pc, exc_addr, trap_arg0, trap_arg1, trap_arg2;
    logic [7:0] err_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] e_pc = '0, e_addr = '0, e_a0 = '0, e_a1 = '0, e_a2 = '0;
    logic [7:0]  e_err = '0;

    always #(PERIOD/2) clk = ~clk;

    exc_dispatch #(.PC_W(PC_W), .FC_W(FC_W)) u0 (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_kind(exc_kind),
        .exc_code(exc_code), .fault_addr(fault_addr), .fault_code(fault_code),
        .fault_acc(fault_acc), .irq_lines(irq_lines), .ipl(ipl), .pc_in(pc_in),
        .pal_base(pal_base), .priv_mode(priv_mode), .redirect_valid(redirect_valid),
        .new_pc(new_pc), .exc_addr(exc_addr), .priv_set(priv_set),
        .err_code(err_code), .kind_err(kind_err), .trap_arg0(trap_arg0),
        .trap_arg1(trap_arg1), .trap_arg2(trap_arg2)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic check_state(input string tag, input bit exp_go, input bit exp_bad);
        chk(redirect_valid == exp_go, {tag, " redirect_valid"}, 64'(redirect_valid), 64'(exp_go));
        chk(priv_set == exp_go, {tag, " priv_set"}, 64'(priv_set), 64'(exp_go));
        chk(kind_err == exp_bad, {tag, " kind_err"}, 64'(kind_err), 64'(exp_bad));
        chk(new_pc == e_pc, {tag, " new_pc"}, new_pc, e_pc);
        chk(exc_addr == e_addr, {tag, " exc_addr"}, exc_addr, e_addr);
        chk(err_code == e_err, {tag, " err_code"}, 64'(err_code), 64'(e_err));
        chk(trap_arg0 == e_a0, {tag, " trap_arg0"}, trap_arg0, e_a0);
        chk(trap_arg1 == e_a1, {tag, " trap_arg1"}, trap_arg1, e_a1);
        chk(trap_arg2 == e_a2, {tag, " trap_arg2"}, trap_arg2, e_a2);
    endtask

    // one stimulus cycle followed by one idle cycle
    task automatic step(input bit req, input logic [3:0] kind, input logic [7:0] code,
                        input logic [3:0] irq, input logic [2:0] lvl,
                        input logic [63:0] pc, input bit pm, input logic [1:0] acc,
                        output bit go, output bit bad);
        int win;
        logic [63:0] off;
        @(negedge clk);
        exc_req = req; exc_kind = kind; exc_code = code; irq_lines = irq;
        ipl = lvl; pc_in = pc; priv_mode = pm; fault_acc = acc;
        fault_addr = pc ^ 64'hA5A5_0000_0000_1234; fault_code = code ^ 8'h3C;
        go = 0; bad = 0; off = 0;
        if (req) begin
            if (kind <= 4'd9) begin go = 1; off = 64'(kind) * 64'h80; end
            else if (kind == 4'd10) begin
                go = 1;
                off = (code >= 8'h80) ? 64'h2000 + (64'(code) - 64'h80) * 64
                                      : 64'h1000 + 64'(code) * 64;
            end else bad = 1;
        end else if (!pm) begin
            win = -1;
            for (int i = 0; i < 4; i++)
                if (irq[i] && int'(lvl) <= 3 + i) win = i;
            if (win >= 0) begin go = 1; off = 64'(4 - win) * 64'h80; end
        end
        if (go) begin
            e_pc = pal_base + off;
            e_addr = pc | 64'(pm);
            e_err = (req) ? code : 8'h00;
            if (req && kind == 4'd5) begin
                e_a0 = fault_addr;
                e_a1 = 64'(fault_code);
                e_a2 = (acc == 2'd0) ? 64'd0 : (acc == 2'd1) ? 64'd1 : '1;
            end
        end
        @(posedge clk); #1;
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        exc_req = 0; irq_lines = '0;
        @(posedge clk); #1;
        chk(redirect_valid == 1'b0, {tag, " pulse ends R7"}, 64'(redirect_valid), 64'd0);
        chk(kind_err == 1'b0, {tag, " error pulse ends R9"}, 64'(kind_err), 64'd0);
    endtask

    initial begin
        #(PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        finish_run();
    end

    initial begin
        bit go, bad;
        repeat (3) @(posedge clk);
        #1;
        check_state("R1 reset", 0, 0);
        @(negedge clk); rst = 0;

        // R2 R3 R4: interrupt sweep over lines, levels and mode
        for (int pm = 0; pm < 2; pm++)
            for (int lv = 0; lv < 8; lv++)
                for (int irq = 0; irq < 16; irq++) begin
                    step(0, 4'd0, 8'h5A, 4'(irq), 3'(lv),
                         64'h1000_0000 + 64'(irq * 4 + lv * 64), bit'(pm), 2'd0, go, bad);
                    check_state(pm ? "R2 irq in priv" : "R3 R4 irq sweep", go, bad);
                    idle("irq");
                end

        // R5 R8 R9 R10 R11: every kind with all lines pending
        for (int pm = 0; pm < 2; pm++)
            for (int k = 0; k < 16; k++) begin
                step(1, 4'(k), 8'(k * 13 + 7), 4'hF, 3'd0,
                     64'h2000_0040 + 64'(k * 8), bit'(pm), 2'(k), go, bad);
                check_state(k > 10 ? "R9 undefined kind" : "R5 R8 R10 R11 kind sweep", go, bad);
                idle("kind");
            end

        // R6: all call codes across both banks
        for (int c = 0; c < 256; c++) begin
            step(1, 4'd10, 8'(c), 4'h0, 3'd7, 64'h3000_0000 + 64'(c * 4), 1'b0, 2'd0, go, bad);
            check_state("R6 call code", go, bad);
            idle("call");
        end

        // R10: each access type for a memory fault
        for (int a = 0; a < 4; a++) begin
            step(1, 4'd5, 8'(a + 1), 4'h0, 3'd7, 64'h4000_0000 + 64'(a * 4), 1'b0, 2'(a), go, bad);
            check_state("R10 access type", go, bad);
            idle("fault");
        end

        finish_run();
    end
endmodule